// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block lets a clocked system read and write an external asynchronous static RAM with 19 address bits and an 8-bit data path. Requests arrive over a valid/ready handshake that carries a read/write flag, an address and write data. Read results come back on a data output together with a one-cycle valid pulse.

On the memory side the controller drives a pair of chip selects with opposite polarity, an active-low output enable, an active-low write enable and the address. The data bus is split into an output value, an output-enable control and an input value, so a pad ring or a board model can resolve it. Every phase of a memory cycle is held for a whole number of clock cycles. Each count is the ceiling of a nanosecond parameter divided by the clock period, and no count is ever below one.

Writes are timed by the write-enable pulse. The output enable stays inactive for the whole write. After a read, the chip is deselected and the bus is left alone for a turnaround time before the next request is accepted.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is held and right after it, req_ready_o is 1, rd_valid_o is 0, sram_ce1_n_o is 1, sram_ce2_o is 0, sram_oe_n_o is 1, sram_we_n_o is 1 and sram_dq_oe_o is 0.
- R2: While idle (req_ready_o is 1), the memory is deselected (sram_ce1_n_o 1, sram_ce2_o 0) and the controller does not drive the data bus.
- R3: A request is taken only on a clock edge where req_valid_i and req_ready_o are both 1. req_ready_o then stays 0 for exactly the cycles of that memory cycle, and requests presented while busy have no effect.
- R4: A read selects the memory (sram_ce1_n_o 0, sram_ce2_o 1), holds sram_oe_n_o at 0 and sram_we_n_o at 1 for RD_CYC = max(cyc(T_AA_NS), cyc(T_RC_NS)) cycles, and samples sram_dq_i on the last of them.
- R5: During a write, sram_oe_n_o stays 1 for every cycle of the memory cycle.
- R6: A write keeps the memory selected, with the address valid and sram_we_n_o at 1, for SETUP_CYC = cyc(T_AS_NS) cycles before sram_we_n_o falls.
- R7: sram_we_n_o is 0 for exactly WP_CYC cycles, where WP_CYC is the largest of cyc(T_WP_NS), cyc(T_AW_NS), cyc(T_DW_NS) and cyc(T_WC_NS) - SETUP_CYC - REC_CYC. Here cyc(t) = max(1, ceil(t / CLK_NS)).
- R8: sram_dq_oe_o is 1 exactly from the cycle in which sram_we_n_o falls until the end of write recovery. sram_dq_o then carries the request's write data unchanged.
- R9: After sram_we_n_o rises, the memory stays selected for REC_CYC = cyc(T_WR_NS) cycles. It is then deselected and the controller returns to idle.
- R10: After a read, the memory is deselected and the bus is undriven for TURN_CYC = cyc(T_HZ_NS) cycles before req_ready_o returns to 1.
- R11: sram_addr_o equals the accepted request address and holds steady in every cycle in which the memory is selected.
- R12: rd_valid_o is 1 for a single cycle, the one right after the last read-access cycle. rd_data_o then holds the byte most recently written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, request will be taken |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (19) | Request address |
| req_wdata_i | input | DATA_W (8) | Write data |
| rd_valid_o | output | 1 | Read data valid pulse |
| rd_data_o | output | DATA_W (8) | Read data |
| sram_ce1_n_o | output | 1 | Chip select, active low |
| sram_ce2_o | output | 1 | Chip select, active high |
| sram_oe_n_o | output | 1 | Output enable, active low |
| sram_we_n_o | output | 1 | Write enable, active low |
| sram_addr_o | output | ADDR_W (19) | Memory address |
| sram_dq_o | output | DATA_W (8) | Data driven toward the memory |
| sram_dq_oe_o | output | 1 | Drive enable for sram_dq_o |
| sram_dq_i | input | DATA_W (8) | Data from the memory |

## Verification
The acceptance edge is cycle 0. A write shows its first memory-side cycle in the cycle after that edge, and a read's valid pulse appears RD_CYC cycles later. req_ready_o returns after SETUP_CYC+WP_CYC+REC_CYC cycles for a write and RD_CYC+TURN_CYC cycles for a read. The bench records every pin once per cycle on the falling clock edge, starting with the cycle after acceptance and stopping when req_ready_o rises. It then checks each phase length, the index of the valid pulse and the returned data against counts it derives itself from the nanosecond parameters. A behavioural memory model commits data only on the rising edge of write enable and flags any cycle in which both sides drive the bus.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WREC,
    ST_RACC,
    ST_RTURN
  } sram_st_e;

  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // R3
  load_when_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> done_o);

endmodule

// File: rtl/sram_pin_decode.sv
module sram_pin_decode
  import sram_ctrl_pkg::*;
(
  input  sram_st_e st_i,
  output logic     ce1_n_o,
  output logic     ce2_o,
  output logic     oe_n_o,
  output logic     we_n_o,
  output logic     dq_oe_o
);

  logic sel;

  always_comb begin
    unique case (st_i)
      ST_WSETUP, ST_WPULSE, ST_WREC, ST_RACC: sel = 1'b1;
      default:                                sel = 1'b0;
    endcase
  end

  assign ce1_n_o = ~sel;
  assign ce2_o   = sel;
  assign oe_n_o  = (st_i != ST_RACC);
  assign we_n_o  = (st_i != ST_WPULSE);
  assign dq_oe_o = (st_i == ST_WPULSE) || (st_i == ST_WREC);

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W  = 19,
  parameter int DATA_W  = 8,
  parameter int CLK_NS  = 20,
  parameter int T_AS_NS = 0,
  parameter int T_AW_NS = 70,
  parameter int T_WP_NS = 60,
  parameter int T_DW_NS = 40,
  parameter int T_WR_NS = 5,
  parameter int T_WC_NS = 85,
  parameter int T_AA_NS = 85,
  parameter int T_RC_NS = 85,
  parameter int T_HZ_NS = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              sram_ce1_n_o,
  output logic              sram_ce2_o,
  output logic              sram_oe_n_o,
  output logic              sram_we_n_o,
  output logic [ADDR_W-1:0] sram_addr_o,
  output logic [DATA_W-1:0] sram_dq_o,
  output logic              sram_dq_oe_o,
  input  logic [DATA_W-1:0] sram_dq_i
);

  localparam int SETUP_CYC = ns_to_cyc(T_AS_NS, CLK_NS);
  localparam int REC_CYC   = ns_to_cyc(T_WR_NS, CLK_NS);
  localparam int WP_CYC    = imax(imax(ns_to_cyc(T_WP_NS, CLK_NS), ns_to_cyc(T_AW_NS, CLK_NS)),
                                  imax(ns_to_cyc(T_DW_NS, CLK_NS),
                                       ns_to_cyc(T_WC_NS, CLK_NS) - SETUP_CYC - REC_CYC));
  localparam int RD_CYC    = imax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_RC_NS, CLK_NS));
  localparam int TURN_CYC  = ns_to_cyc(T_HZ_NS, CLK_NS);
  localparam int MAX_CYC   = imax(imax(SETUP_CYC, WP_CYC), imax(imax(REC_CYC, RD_CYC), TURN_CYC));
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LD    = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LD   = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LD    = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] TURN_LD  = CNT_W'(TURN_CYC - 1);

  sram_st_e          state_q, state_d;
  logic              load;
  logic [CNT_W-1:0]  load_val;
  logic              done;
  logic              accept;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              rvalid_q;

  assign req_ready_o = (state_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .done_o     (done)
  );

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        load = 1'b1;
        if (req_we_i) begin state_d = ST_WSETUP; load_val = SETUP_LD; end
        else          begin state_d = ST_RACC;   load_val = RD_LD;    end
      end
      ST_WSETUP: if (done) begin state_d = ST_WPULSE; load = 1'b1; load_val = WP_LD;   end
      ST_WPULSE: if (done) begin state_d = ST_WREC;   load = 1'b1; load_val = REC_LD;  end
      ST_WREC:   if (done) state_d = ST_IDLE;
      ST_RACC:   if (done) begin state_d = ST_RTURN;  load = 1'b1; load_val = TURN_LD; end
      ST_RTURN:  if (done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      rvalid_q <= (state_q == ST_RACC) && done;
      if (accept) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
      end
      // sample on the final access cycle, after the full access time
      if ((state_q == ST_RACC) && done) rdata_q <= sram_dq_i;
    end
  end

  sram_pin_decode u_pins (
    .st_i    (state_q),
    .ce1_n_o (sram_ce1_n_o),
    .ce2_o   (sram_ce2_o),
    .oe_n_o  (sram_oe_n_o),
    .we_n_o  (sram_we_n_o),
    .dq_oe_o (sram_dq_oe_o)
  );

  assign sram_addr_o = addr_q;
  assign sram_dq_o   = wdata_q;
  assign rd_valid_o  = rvalid_q;
  assign rd_data_o   = rdata_q;

  logic sel;
  assign sel = !sram_ce1_n_o && sram_ce2_o;

  // R2
  idle_deselect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!sel && !sram_dq_oe_o));

  // R5
  write_oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_n_o |-> (sram_oe_n_o && sel));

  // R8
  drive_no_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> (sram_oe_n_o && sel));

  // R8
  data_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sram_dq_oe_o && $past(sram_dq_oe_o)) |-> $stable(sram_dq_o));

  // R11
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && $past(sel)) |-> $stable(sram_addr_o));

  // R12
  rd_after_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> ($past(!sram_oe_n_o) && sram_oe_n_o && !rd_valid_o == 1'b0));

  // R3
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_ready_o) |-> $past(req_valid_i));

endmodule

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test;

  localparam int AW = 19, DW = 8, CLK = 20;
  localparam int TAS = 0, TAW = 70, TWP = 60, TDW = 40, TWR = 5, TWC = 85;
  localparam int TAA = 85, TRC = 85, THZ = 30;

  function automatic int bc(input int ns);
    int c;
    c = (ns + CLK - 1) / CLK;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_SET  = bc(TAS);
  localparam int E_REC  = bc(TWR);
  localparam int E_WP   = mx(mx(bc(TWP), bc(TAW)), mx(bc(TDW), bc(TWC) - E_SET - E_REC));
  localparam int E_RD   = mx(bc(TAA), bc(TRC));
  localparam int E_TURN = bc(THZ);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid, ce1_n, ce2, oe_n, we_n, dq_oe;
  logic [DW-1:0] rd_data, dq_o, dq_i;
  logic [AW-1:0] m_addr;

  always #(CLK/2) clk = ~clk;

  sram_ctrl #(.CLK_NS(CLK), .T_AS_NS(TAS), .T_AW_NS(TAW), .T_WP_NS(TWP), .T_DW_NS(TDW),
              .T_WR_NS(TWR), .T_WC_NS(TWC), .T_AA_NS(TAA), .T_RC_NS(TRC), .T_HZ_NS(THZ)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_we_i(req_we), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .sram_ce1_n_o(ce1_n), .sram_ce2_o(ce2),
    .sram_oe_n_o(oe_n), .sram_we_n_o(we_n), .sram_addr_o(m_addr), .sram_dq_o(dq_o),
    .sram_dq_oe_o(dq_oe), .sram_dq_i(dq_i));

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // memory model
  logic [7:0] mem [int];
  logic [7:0] shadow [int];
  logic prev_we_n = 1'b1;
  logic m_sel, m_drive;
  assign m_sel   = !ce1_n && ce2;
  assign m_drive = m_sel && !oe_n && we_n;
  always @(*) dq_i = (m_drive && mem.exists(int'(m_addr))) ? mem[int'(m_addr)] : 8'h00;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!prev_we_n && we_n && m_sel) mem[int'(m_addr)] = dq_o;
      if (m_drive && dq_oe) chk(1'b0, "R8 bus contention", 1, 0);
    end
    prev_we_n = we_n;
  end

  // per-operation trace
  logic t_sel [64];
  logic t_oen [64];
  logic t_wen [64];
  logic t_doe [64];
  logic t_rv  [64];
  logic [AW-1:0] t_addr [64];
  logic [DW-1:0] t_dq   [64];
  logic [DW-1:0] t_rd   [64];
  int t_n;

  task automatic run_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit poke);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    if (poke) begin
      req_we = 1'b1; req_addr = a ^ 19'h00100; req_wdata = ~d;
    end else req_valid = 1'b0;
    t_n = 0;
    forever begin
      @(negedge clk);
      if (req_ready || t_n == 64) break;
      t_sel[t_n] = !ce1_n && ce2; t_oen[t_n] = oe_n; t_wen[t_n] = we_n; t_doe[t_n] = dq_oe;
      t_rv[t_n] = rd_valid; t_addr[t_n] = m_addr; t_dq[t_n] = dq_o; t_rd[t_n] = rd_data;
      t_n++;
    end
    req_valid = 1'b0;
    chk(ce1_n && !ce2 && !dq_oe, "R2 idle deselected", int'(ce1_n), 1);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit poke);
    int s, p, r, falls;
    bit oe_ok, drv_ok, addr_ok;
    run_op(1'b1, a, d, poke);
    shadow[int'(a)] = d;
    s = 0; p = 0; r = 0; falls = 0; oe_ok = 1; drv_ok = 1; addr_ok = 1;
    for (int i = 0; i < t_n; i++) begin
      if (!t_wen[i]) p++;
      else if (p == 0 && t_sel[i]) s++;
      else if (p > 0 && t_sel[i]) r++;
      if (i > 0 && t_wen[i-1] && !t_wen[i]) falls++;
      if (i == 0 && !t_wen[i]) falls++;
      if (!t_oen[i]) oe_ok = 0;
      if (t_doe[i] != (p > 0 && t_sel[i])) drv_ok = 0;
      if (t_doe[i] && t_dq[i] != d) drv_ok = 0;
      if (t_sel[i] && t_addr[i] != a) addr_ok = 0;
    end
    chk(t_n == E_SET + E_WP + E_REC, "R3 write busy length", t_n, E_SET + E_WP + E_REC);
    chk(falls == 1, "R3 single write strobe", falls, 1);
    chk(oe_ok, "R5 oe high in write", 0, 1);
    chk(s == E_SET, "R6 setup cycles", s, E_SET);
    chk(p == E_WP, "R7 we low cycles", p, E_WP);
    chk(drv_ok, "R8 drive window/data", 0, 1);
    chk(r == E_REC, "R9 recovery cycles", r, E_REC);
    chk(addr_ok, "R11 address held", 0, 1);
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    int acc, idle, rv_cnt, rv_idx;
    bit addr_ok;
    logic [DW-1:0] got, exp;
    run_op(1'b0, a, 8'h00, 1'b0);
    exp = shadow.exists(int'(a)) ? shadow[int'(a)] : 8'h00;
    acc = 0; idle = 0; rv_cnt = 0; rv_idx = -1; addr_ok = 1; got = '0;
    for (int i = 0; i < t_n; i++) begin
      if (t_sel[i] && !t_oen[i] && t_wen[i] && idle == 0) acc++;
      else if (!t_sel[i] && !t_doe[i] && t_oen[i]) idle++;
      if (t_rv[i]) begin rv_cnt++; rv_idx = i; got = t_rd[i]; end
      if (t_sel[i] && t_addr[i] != a) addr_ok = 0;
    end
    chk(t_n == E_RD + E_TURN, "R3 read busy length", t_n, E_RD + E_TURN);
    chk(acc == E_RD, "R4 access cycles", acc, E_RD);
    chk(idle == E_TURN, "R10 turnaround cycles", idle, E_TURN);
    chk(rv_cnt == 1 && rv_idx == E_RD, "R12 valid pulse position", rv_idx, E_RD);
    chk(got == exp, "R12 read data", int'(got), int'(exp));
    chk(addr_ok, "R11 address held", 0, 1);
  endtask

  bit done_flag = 0;
  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 1, 0);
    finish_run();
  end

  logic [AW-1:0] pool [8];
  initial begin
    void'($urandom(32'h5eed1234));
    pool[0] = 19'h00000; pool[1] = 19'h7FFFF; pool[2] = 19'h00001; pool[3] = 19'h55555;
    pool[4] = 19'h2AAAA; pool[5] = 19'h40000; pool[6] = 19'h3FFFF; pool[7] = 19'h12345;
    repeat (3) @(negedge clk);
    // R1
    chk(req_ready && !rd_valid && ce1_n && !ce2 && oe_n && we_n && !dq_oe, "R1 reset outputs", 0, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && ce1_n && !ce2 && !dq_oe && !rd_valid, "R1 after reset", 0, 1);
    for (int i = 0; i < 8; i++) do_write(pool[i], 8'($urandom), 1'b0);
    // R12 corner addresses
    do_read(19'h7FFFF);
    do_read(19'h00000);
    for (int k = 0; k < 60; k++) begin
      logic [AW-1:0] a;
      a = pool[$urandom % 8];
      if ($urandom % 2) do_write(a, 8'($urandom), 1'b0);
      else do_read(a);
    end
    // R3 request held during busy must not be taken
    do_write(19'h00100 ^ 19'h00100, 8'hA5, 1'b0);
    do_write(19'h00200, 8'h3C, 1'b0);
    shadow[int'(19'h00300)] = 8'h00;
    do_write(19'h00200, 8'h77, 1'b1);
    do_read(19'h00300);
    do_read(19'h00200);
    // back to back reads then write
    do_read(19'h00200);
    do_write(19'h00200, 8'hFF, 1'b0);
    do_read(19'h00200);
    finish_run();
  end

endmodule